// File: doc/BRIEF.md
# Context-Switched Array Processing Cell

This block is one processing element for a coarse-grained reconfigurable array. It contains a word-wide functional unit, a four-entry local register file, two operand multiplexers and a small store of configuration contexts. On every clock edge the cell runs the context named by the context index input. That context gives the operation, where each operand comes from, whether the result goes to the register file and the output register, and whether the step depends on the incoming predicate bit.

The surrounding array steers the context index each cycle. It feeds the four neighbour ports and the predicate input. New configuration words arrive through a separate load port with a valid/ready handshake. That port is slower than a context switch: a loaded word lands one cycle after acceptance, and the port cannot take another word in the following cycle. Each instance carries a mask of the operations it implements, so cells in one array can differ. Any opcode outside the mask does nothing.

Top module: `rca_cell`

## Requirements
- R1: While reset is held and after it is released, `out_o` and `pred_o` are 0 and `cfg_ready_o` is 1. All four register entries read 0, and all four contexts hold opcode 0, which changes nothing when selected.
- R2: The configuration word is 27 bits, MSB first: opcode [26:23], source A [22:20], source B [19:17], read address A [16:15], read address B [14:13], register write enable [12], register write address [11:10], output enable [9], predicate enable [8], immediate [7:0]. The context named by `ctx_sel_i` in a cycle is executed at the next rising edge. Its result appears on `out_o` after that edge, and a different context may be selected on every cycle.
- R3: Operand select codes are 0 north, 1 east, 2 south, 3 west, 4 register entry at the operand's read address, 5 immediate zero-extended, 6 the current `out_o`, 7 zero.
- R4: Opcodes compute modulo 2^16: 1 A+B, 2 A-B, 3 A AND B, 4 A OR B, 5 A XOR B, 6 A shifted left by B[3:0], 7 A shifted right logically by B[3:0], 8 low 16 bits of A*B, 10 A passed through.
- R5: Opcode 9 compares A and B unsigned. It produces 1 if A<B and 0 otherwise, and it loads the same bit into `pred_o`. Other opcodes leave `pred_o` unchanged.
- R6: With write enable set, the result is written to the entry at the write address and is readable through source code 4 from the next cycle. With output enable clear, `out_o` keeps its value.
- R7: With predicate enable set and `pred_i` low, the step writes neither the register file nor `out_o` and leaves `pred_o` unchanged.
- R8: Opcode 0, opcodes 11 to 15, and any opcode missing from the instance's operation mask change no register entry, `out_o` or `pred_o`.
- R9: A load word is accepted when `cfg_valid_i` and `cfg_ready_o` are both high. `cfg_ready_o` is low in the next cycle and high again in the cycle after that. The word is executable from the second cycle after acceptance. The environment must not select a context while a load into it is pending.
- R10: Reloading one context leaves the contents of every other context unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctx_sel_i | input | 2 | Context to execute this cycle |
| nbr_n_i | input | 16 | North neighbour operand |
| nbr_e_i | input | 16 | East neighbour operand |
| nbr_s_i | input | 16 | South neighbour operand |
| nbr_w_i | input | 16 | West neighbour operand |
| pred_i | input | 1 | Predicate for predicated steps |
| cfg_valid_i | input | 1 | Load word offered |
| cfg_ready_o | output | 1 | Load port can accept a word |
| cfg_idx_i | input | 2 | Context the offered word replaces |
| cfg_word_i | input | 27 | Configuration word to load |
| out_o | output | 16 | Registered result |
| pred_o | output | 1 | Registered comparison flag |

## Verification
The bench sweeps all sixteen opcodes against every operand source and a range of operand patterns. These include all-ones, the sign bit and shift counts of 0 and 15. A wrong carry, sign or shift width would show as a mismatch on `out_o`. It runs predicated steps with the predicate low, and a cell that ignored predication would overwrite `out_o` or a register entry. It also runs unsupported opcodes, and a cell that decoded them as real operations would change its state. A comparison whose flag came from the wrong operand order would flip `pred_o`. Contexts are switched on consecutive cycles and one context is reloaded next to others, which exposes stale reads and a load that hits the wrong slot. The ready pattern of the load port is checked on every word.

// File: rtl/rca_cell_pkg.sv
package rca_cell_pkg;

  localparam int CTX_N = 4;
  localparam int CTX_W = $clog2(CTX_N);
  localparam int REG_N = 4;
  localparam int REG_W = $clog2(REG_N);
  localparam int OP_W  = 4;
  localparam int SEL_W = 3;
  localparam int IMM_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_MUL  = 4'd8,
    OP_CLT  = 4'd9,
    OP_PASS = 4'd10
  } op_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_NORTH = 3'd0,
    SRC_EAST  = 3'd1,
    SRC_SOUTH = 3'd2,
    SRC_WEST  = 3'd3,
    SRC_REG   = 3'd4,
    SRC_IMM   = 3'd5,
    SRC_FB    = 3'd6,
    SRC_ZERO  = 3'd7
  } src_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [REG_W-1:0] ra_a;
    logic [REG_W-1:0] ra_b;
    logic             rf_we;
    logic [REG_W-1:0] rf_wa;
    logic             out_en;
    logic             pred_en;
    logic [IMM_W-1:0] imm;
  } cfg_t;

  localparam int   CFG_W   = $bits(cfg_t);
  localparam cfg_t CFG_IDLE = '0;

endpackage

// File: rtl/rca_cell_rst_sync.sv
module rca_cell_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/rca_cell_cfg_store.sv
module rca_cell_cfg_store
  import rca_cell_pkg::*;
#(
  parameter int NCTX = CTX_N,
  localparam int IW  = $clog2(NCTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    sel_i,
  output cfg_t             ctx_o,
  input  logic             ld_valid_i,
  output logic             ld_ready_o,
  input  logic [IW-1:0]    ld_idx_i,
  input  logic [CFG_W-1:0] ld_word_i
);

  logic          pend_q;
  logic          pend_d;
  logic [IW-1:0] pend_idx_q;
  cfg_t          pend_word_q;
  logic          accept;
  logic [NCTX-1:0] slot_we;
  cfg_t          slot_w [NCTX];

  assign ld_ready_o = !pend_q;
  assign accept     = ld_valid_i && ld_ready_o;

  always_comb begin
    pend_d = accept;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_idx_q  <= '0;
      pend_word_q <= CFG_IDLE;
    end else if (accept) begin
      pend_idx_q  <= ld_idx_i;
      pend_word_q <= cfg_t'(ld_word_i);
    end
  end

  for (genvar g = 0; g < NCTX; g++) begin : g_slot
    cfg_t slot_q;
    assign slot_we[g] = pend_q && (pend_idx_q == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= CFG_IDLE;
      end else if (slot_we[g]) begin
        slot_q <= pend_word_q;
      end
    end
    assign slot_w[g] = slot_q;
  end

  assign ctx_o = slot_w[sel_i];

  AST_LOAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ld_ready_o); // R9

  AST_LOAD_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ready_o |=> ld_ready_o); // R9

  AST_PENDING_NOT_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (sel_i != pend_idx_q)); // R9

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_we)); // R10

endmodule

// File: rtl/rca_cell_regfile.sv
module rca_cell_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);

  logic [DW-1:0]   ent_w [NREG];
  logic [NREG-1:0] ent_we;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    assign ent_we[g] = we_i && (wa_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (ent_we[g]) begin
        ent_q <= wd_i;
      end
    end
    assign ent_w[g] = ent_q;
  end

  assign rd_a_o = ent_w[ra_a_i];
  assign rd_b_o = ent_w[ra_b_i];

  AST_RF_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ent_we)); // R6

  AST_RF_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wa_i == ra_a_i)) |=> (rd_a_o == $past(wd_i)) || (ra_a_i != $past(ra_a_i))); // R6

endmodule

// File: rtl/rca_cell_alu.sv
module rca_cell_alu
  import rca_cell_pkg::*;
#(
  parameter int          DW    = 16,
  parameter logic [15:0] OP_EN = 16'h07FE,
  localparam int         SHW   = $clog2(DW)
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            sup_o,
  output logic            cmp_o
);

  logic [DW-1:0]  mul_lo;
  logic [SHW-1:0] sh_amt;

  assign sh_amt = b_i[SHW-1:0];

  if (OP_EN[OP_MUL]) begin : g_mul
    assign mul_lo = a_i * b_i;
  end else begin : g_no_mul
    assign mul_lo = '0;
  end

  always_comb begin
    sup_o = (op_i >= OP_ADD) && (op_i <= OP_PASS) && OP_EN[op_i];
    cmp_o = sup_o && (op_i == OP_CLT);
  end

  always_comb begin
    res_o = '0;
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SHL:  res_o = a_i << sh_amt;
      OP_SHR:  res_o = a_i >> sh_amt;
      OP_MUL:  res_o = mul_lo;
      OP_CLT:  res_o = {{(DW-1){1'b0}}, (a_i < b_i)};
      OP_PASS: res_o = a_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (cmp_o) begin
      AST_CMP_IS_BIT: assert (res_o[DW-1:1] == '0); // R5
    end
  end

endmodule

// File: rtl/rca_cell.sv
module rca_cell
  import rca_cell_pkg::*;
#(
  parameter int          DW    = 16,
  parameter logic [15:0] OP_EN = 16'h07FE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTX_W-1:0] ctx_sel_i,
  input  logic [DW-1:0]    nbr_n_i,
  input  logic [DW-1:0]    nbr_e_i,
  input  logic [DW-1:0]    nbr_s_i,
  input  logic [DW-1:0]    nbr_w_i,
  input  logic             pred_i,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [CTX_W-1:0] cfg_idx_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic [DW-1:0]    out_o,
  output logic             pred_o
);

  logic          rst_n;
  cfg_t          cur;
  logic [DW-1:0] rf_a, rf_b;
  logic [DW-1:0] opnd_a, opnd_b;
  logic [DW-1:0] alu_res;
  logic          alu_sup, alu_cmp;
  logic          exec;
  logic          rf_we;
  logic [DW-1:0] out_q, out_d;
  logic          pred_q, pred_d;
  logic [DW-1:0] imm_ext;

  rca_cell_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  rca_cell_cfg_store #(.NCTX(CTX_N)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sel_i      (ctx_sel_i),
    .ctx_o      (cur),
    .ld_valid_i (cfg_valid_i),
    .ld_ready_o (cfg_ready_o),
    .ld_idx_i   (cfg_idx_i),
    .ld_word_i  (cfg_word_i)
  );

  rca_cell_regfile #(.DW(DW), .NREG(REG_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .ra_a_i (cur.ra_a),
    .ra_b_i (cur.ra_b),
    .rd_a_o (rf_a),
    .rd_b_o (rf_b),
    .we_i   (rf_we),
    .wa_i   (cur.rf_wa),
    .wd_i   (alu_res)
  );

  assign imm_ext = {{(DW-IMM_W){1'b0}}, cur.imm};

  function automatic logic [DW-1:0] pick(
    input logic [SEL_W-1:0] sel,
    input logic [DW-1:0]    n, e, s, w, rf, imm, fb
  );
    logic [DW-1:0] v;
    case (sel)
      SRC_NORTH: v = n;
      SRC_EAST:  v = e;
      SRC_SOUTH: v = s;
      SRC_WEST:  v = w;
      SRC_REG:   v = rf;
      SRC_IMM:   v = imm;
      SRC_FB:    v = fb;
      default:   v = '0;
    endcase
    return v;
  endfunction

  always_comb begin
    opnd_a = pick(cur.src_a, nbr_n_i, nbr_e_i, nbr_s_i, nbr_w_i, rf_a, imm_ext, out_q);
    opnd_b = pick(cur.src_b, nbr_n_i, nbr_e_i, nbr_s_i, nbr_w_i, rf_b, imm_ext, out_q);
  end

  rca_cell_alu #(.DW(DW), .OP_EN(OP_EN)) u_alu (
    .op_i  (cur.op),
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .res_o (alu_res),
    .sup_o (alu_sup),
    .cmp_o (alu_cmp)
  );

  always_comb begin
    exec   = alu_sup && (!cur.pred_en || pred_i);
    rf_we  = exec && cur.rf_we;
    out_d  = (exec && cur.out_en) ? alu_res : out_q;
    pred_d = (exec && alu_cmp) ? alu_res[0] : pred_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      pred_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      pred_q <= pred_d;
    end
  end

  assign out_o  = out_q;
  assign pred_o = pred_q;

  AST_PRED_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cur.pred_en && !pred_i) |=> ($stable(out_o) && $stable(pred_o))); // R7

  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    !alu_sup |=> ($stable(out_o) && $stable(pred_o))); // R8

  AST_OUT_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (exec && cur.out_en) |=> (out_o == $past(alu_res))); // R2

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cur.out_en |=> $stable(out_o)); // R6

endmodule

// File: tb/rca_cell_tb.sv
`timescale 1ns/1ps
module rca_cell_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [1:0]  ctx_sel;
  logic [15:0] nn, ne, ns, nw;
  logic        pred_in;
  logic        cfg_valid;
  logic        cfg_ready;
  logic [1:0]  cfg_idx;
  logic [26:0] cfg_word;
  logic [15:0] out_w;
  logic        pred_w;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mrf [4];
  logic [15:0] mout;
  logic        mpred;
  logic [26:0] bctx [4];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rca_cell dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ctx_sel_i   (ctx_sel),
    .nbr_n_i     (nn),
    .nbr_e_i     (ne),
    .nbr_s_i     (ns),
    .nbr_w_i     (nw),
    .pred_i      (pred_in),
    .cfg_valid_i (cfg_valid),
    .cfg_ready_o (cfg_ready),
    .cfg_idx_i   (cfg_idx),
    .cfg_word_i  (cfg_word),
    .out_o       (out_w),
    .pred_o      (pred_w)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] mk(input int op, input int sa, input int sb,
                                     input int raa, input int rab, input int we,
                                     input int wa, input int oe, input int pe, input int imm);
    return {op[3:0], sa[2:0], sb[2:0], raa[1:0], rab[1:0], we[0], wa[1:0], oe[0], pe[0], imm[7:0]};
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [15:0] src(input logic [2:0] s, input logic [1:0] ra, input logic [7:0] imm);
    case (s)
      3'd0: return nn;
      3'd1: return ne;
      3'd2: return ns;
      3'd3: return nw;
      3'd4: return mrf[ra];
      3'd5: return {8'h00, imm};
      3'd6: return mout;
      default: return 16'h0000;
    endcase
  endfunction

  // Applies one step to the bench model and returns the requirement it exercises.
  function automatic string model_step(input logic [26:0] w);
    logic [3:0]  op  = w[26:23];
    logic [15:0] a   = src(w[22:20], w[16:15], w[7:0]);
    logic [15:0] b   = src(w[19:17], w[14:13], w[7:0]);
    logic [15:0] r   = 16'h0;
    logic        sup = (op >= 4'd1) && (op <= 4'd10);
    logic        run;
    string       tag;
    case (op)
      4'd1:  r = a + b;
      4'd2:  r = a - b;
      4'd3:  r = a & b;
      4'd4:  r = a | b;
      4'd5:  r = a ^ b;
      4'd6:  r = a << b[3:0];
      4'd7:  r = a >> b[3:0];
      4'd8:  r = 16'(a * b);
      4'd9:  r = (a < b) ? 16'd1 : 16'd0;
      4'd10: r = a;
      default: r = 16'h0;
    endcase
    run = sup && (!w[8] || pred_in);
    if (!sup) tag = "R8";
    else if (!run) tag = "R7";
    else if (op == 4'd9) tag = "R5";
    else if (w[22:20] == 3'd4 || w[19:17] == 3'd4) tag = "R3/R6";
    else tag = "R4";
    if (run) begin
      if (w[12]) mrf[w[11:10]] = r;
      if (w[9]) mout = r;
      if (op == 4'd9) mpred = r[0];
    end
    return tag;
  endfunction

  task automatic load(input int idx, input logic [26:0] w);
    @(negedge clk);
    chk("R9 ready before offer", {15'h0, cfg_ready}, 16'd1);
    cfg_valid = 1'b1;
    cfg_idx   = idx[1:0];
    cfg_word  = w;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R9 ready low after accept", {15'h0, cfg_ready}, 16'd0);
    @(negedge clk);
    chk("R9 ready back", {15'h0, cfg_ready}, 16'd1);
    bctx[idx] = w;
  endtask

  // Selects context c for one cycle at a falling edge and checks the outputs at the next.
  task automatic step(input int c, input logic pr, input string force_tag);
    string tag;
    ctx_sel = c[1:0];
    pred_in = pr;
    tag = model_step(bctx[c]);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    chk({tag, " out"}, out_w, mout);
    chk({tag, " pred"}, {15'h0, pred_w}, {15'h0, mpred});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    ctx_sel = 2'd3; nn = 16'h1111; ne = 16'h2222; ns = 16'h3333; nw = 16'h4444;
    pred_in = 1'b1; cfg_valid = 1'b0; cfg_idx = 2'd0; cfg_word = '0;
    for (int i = 0; i < 4; i++) begin mrf[i] = 16'h0; bctx[i] = '0; end
    mout = 16'h0; mpred = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out in reset", out_w, 16'h0);
    chk("R1 ready in reset", {15'h0, cfg_ready}, 16'd1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out after reset", out_w, 16'h0);
    chk("R1 pred after reset", {15'h0, pred_w}, 16'h0);

    // R1: every context starts as a no-op.
    for (int c = 0; c < 4; c++) step(c, 1'b1, "R1 ctx");
    ctx_sel = 2'd3;
    // R1: register entries start at zero (pass register through, source code 4).
    for (int r = 0; r < 4; r++) begin
      load(0, mk(10, 4, 7, r, 0, 0, 0, 1, 0, 0));
      step(0, 1'b1, "R1 reg");
      ctx_sel = 2'd3;
    end

    // R6: write a register without touching the output, then read it back.
    nn = 16'hBEEF; ne = 16'h0101;
    load(1, mk(1, 0, 1, 0, 0, 1, 2, 0, 0, 0));
    step(1, 1'b1, "R6 write no out");
    ctx_sel = 2'd3;
    load(2, mk(10, 4, 7, 2, 0, 0, 0, 1, 0, 0));
    step(2, 1'b1, "R6 readback");
    ctx_sel = 2'd3;

    // R2: switch context on consecutive cycles without parking.
    load(0, mk(1, 0, 1, 0, 0, 0, 0, 1, 0, 0));
    load(1, mk(2, 0, 5, 0, 0, 0, 0, 1, 0, 8'h7F));
    load(2, mk(5, 6, 3, 0, 0, 0, 0, 1, 0, 0));
    nn = 16'h8000; ne = 16'h7FFF; nw = 16'h00FF;
    for (int k = 0; k < 9; k++) step(k % 3, 1'b1, "R2 switch");
    ctx_sel = 2'd3;

    // R10: reload context 0, contexts 1 and 2 keep their contents.
    load(0, mk(3, 0, 1, 0, 0, 0, 0, 1, 0, 0));
    step(1, 1'b1, "R10 ctx1 kept");
    step(2, 1'b1, "R10 ctx2 kept");
    step(0, 1'b1, "R10 ctx0 new");
    ctx_sel = 2'd3;

    // Sweep: all opcodes against rotating sources, flags and operand patterns.
    for (int op = 0; op < 16; op++) begin
      for (int p = 0; p < 6; p++) begin
        int c = (op + p) % 3;
        logic [26:0] w;
        lfsr = nxt(lfsr); nn = (p == 0) ? 16'hFFFF : lfsr;
        lfsr = nxt(lfsr); ne = (p == 0) ? 16'h000F : (p == 1 ? 16'h0000 : lfsr);
        lfsr = nxt(lfsr); ns = (p == 2) ? 16'h8000 : lfsr;
        lfsr = nxt(lfsr); nw = lfsr;
        w = mk(op, (op + p) % 8, (op * 3 + p) % 8, p % 4, (p + 1) % 4, p % 2,
               (op + p) % 4, (p != 3) ? 1 : 0, (p >= 4) ? 1 : 0, int'(lfsr[7:0]));
        load(c, w);
        step(c, (p == 4) ? 1'b0 : 1'b1, "");
        ctx_sel = 2'd3;
      end
    end

    // R6: final register contents match the model.
    for (int r = 0; r < 4; r++) begin
      load(0, mk(10, 4, 7, r, 0, 0, 0, 1, 0, 0));
      step(0, 1'b1, "R6 final reg");
      ctx_sel = 2'd3;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule